// File: doc/BRIEF.md
# Receive DMA Idle Timeout and Completion Status

This block is the control and status slice of a receive DMA channel that carries bytes from a serial receiver into host-bound packet buffers. It owns one 8-bit register. The register holds a timeout enable, a 5-bit timeout value in frame-tick units (one tick per millisecond, so 0 to 31 ms), and two sticky completion flags. A down counter is reloaded from the timeout value each time a byte is moved. It counts down on frame-start ticks. When the counter expires, the block halts the transfer and records why.

The block also watches three fullness inputs: the X packet buffer, the Y packet buffer and the receive FIFO. When all three become full together, the block reports a host-busy overrun. Completion codes read as timeout/overrun = 1/0 for data starvation, 1/1 for host-busy overrun and 0/0 for a receiver error. Software clears each flag by writing 1 to it. When the interrupt enable input is low, the channel stays enabled after a completion, ready for the next transaction. When it is high, the completion drops the channel enable and emits an interrupt pulse.

Top module: `rxdma_rx_timeout`

## Requirements
- R1: After synchronous reset, `reg_rdata` reads 0x00, `chan_en` is 0, and `irq_pulse` and `halt_pulse` are 0.
- R2: A register write stores bit 7 as the timeout enable and bits 6..2 as the timeout value. Both read back at the same positions on `reg_rdata` in the cycle after the write.
- R3: Bit 1 (timeout flag) and bit 0 (overrun flag) are cleared by writing 1 and are unchanged by writing 0. A hardware set in the same cycle as a software clear leaves the flag set.
- R4: A byte transfer while `chan_en` is 1 reloads the counter from the timeout value. A byte transfer and a frame tick in the same cycle act as a reload only.
- R5: The counter counts only while the timeout enable is 1, `chan_en` is 1 and a byte has been moved since the channel was enabled or last terminated. Frame ticks at any other time do nothing.
- R6: With value N≥1, expiry occurs on the Nth frame tick after the last byte. With value 0, it occurs on the first tick. Expiry sets bit 1 and pulses `halt_pulse` for one cycle. The timer then stays idle until the next byte.
- R7: The cycle in which X full, Y full and FIFO full all become true together, with `chan_en` at 1, sets both bit 1 and bit 0 and pulses `halt_pulse`. Holding the condition produces no further event.
- R8: `uart_err` while `chan_en` is 1 pulses `halt_pulse` and disarms the timer. It changes neither flag.
- R9: With `ien` at 0, a flag-setting completion leaves `chan_en` at 1 and `irq_pulse` at 0.
- R10: With `ien` at 1, a flag-setting completion clears `chan_en` and raises `irq_pulse` for exactly one cycle, together with `halt_pulse`.
- R11: `en_wr` loads `chan_en` from `en_wdata`. Byte transfers while `chan_en` is 0 are ignored. A hardware clear wins over a same-cycle write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register contents: enable, value, timeout flag, overrun flag |
| ien | input | 1 | Interrupt enable from the channel descriptor |
| en_wr | input | 1 | Channel enable write strobe |
| en_wdata | input | 1 | Channel enable write value |
| chan_en | output | 1 | Channel enable state |
| byte_xfer | input | 1 | One byte moved this cycle |
| sof_tick | input | 1 | Frame-start tick, one per millisecond |
| bufx_full | input | 1 | X packet buffer full |
| bufy_full | input | 1 | Y packet buffer full |
| fifo_full | input | 1 | Receive FIFO full |
| uart_err | input | 1 | Receiver error indication |
| irq_pulse | output | 1 | One-cycle interrupt on flag-setting completion when `ien` is 1 |
| halt_pulse | output | 1 | One-cycle pulse on any termination |

## Verification
The bench targets a byte arriving in the same cycle as a frame tick. A design that lets the decrement win would expire one tick early. It checks that a zero timeout value expires on the first tick rather than wrapping to 31 ms. It checks that the timer waits for the first byte, so a design armed by the enable alone would halt an idle channel. It also writes 0 to a set flag, clears a flag in the same cycle that hardware sets it, and holds the overrun condition for several cycles. A design that treats write-0 as a clear, lets the clear win, or reports a held level as fresh overruns would lose or duplicate a completion code.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  localparam int CSR_W   = 8;
  localparam int TV_W    = 5;
  localparam int BIT_TEN = 7;
  localparam int TV_LSB  = 2;
  localparam int BIT_TMO = 1;
  localparam int BIT_OVR = 0;
endpackage

// File: rtl/rxdma_idle_timer.sv
module rxdma_idle_timer #(
  parameter int TV_W = rxdma_pkg::TV_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ten,
  input  logic [TV_W-1:0] tval,
  input  logic            chan_en,
  input  logic            byte_xfer,
  input  logic            sof_tick,
  input  logic            other_term,
  output logic            tmo_evt
);
  localparam logic [TV_W-1:0] ONE = TV_W'(1);

  logic [TV_W-1:0] cnt_q;
  logic            seen_byte_q;
  logic            armed;
  logic            take_byte;

  assign take_byte = byte_xfer & chan_en;
  assign armed     = ten & chan_en & seen_byte_q;
  // value 0 and value 1 both expire on the first tick
  assign tmo_evt   = armed & sof_tick & ~take_byte & (cnt_q <= ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q       <= '0;
      seen_byte_q <= 1'b0;
    end else if (!chan_en) begin
      seen_byte_q <= 1'b0;
    end else if (take_byte) begin
      cnt_q       <= tval;
      seen_byte_q <= 1'b1;
    end else if (tmo_evt || other_term) begin
      seen_byte_q <= 1'b0;
    end else if (armed && sof_tick) begin
      cnt_q <= cnt_q - ONE;
    end
  end
endmodule

// File: rtl/rxdma_ovr_detect.sv
module rxdma_ovr_detect (
  input  logic clk,
  input  logic rst,
  input  logic chan_en,
  input  logic bufx_full,
  input  logic bufy_full,
  input  logic fifo_full,
  output logic ovr_evt
);
  logic all_full;
  logic all_full_q;

  assign all_full = bufx_full & bufy_full & fifo_full;
  assign ovr_evt  = chan_en & all_full & ~all_full_q;

  always_ff @(posedge clk) begin
    if (rst) all_full_q <= 1'b0;
    else     all_full_q <= all_full;
  end
endmodule

// File: rtl/rxdma_csr.sv
module rxdma_csr
  import rxdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [CSR_W-1:0] reg_wdata,
  input  logic             ien,
  input  logic             en_wr,
  input  logic             en_wdata,
  input  logic             tmo_evt,
  input  logic             ovr_evt,
  input  logic             err_evt,
  output logic             ten,
  output logic [TV_W-1:0]  tval,
  output logic             flag_tmo,
  output logic             flag_ovr,
  output logic             chan_en,
  output logic             irq_pulse,
  output logic             halt_pulse
);
  logic flag_evt;
  logic clr_tmo;
  logic clr_ovr;

  // overrun reports as timeout plus overrun
  assign flag_evt = tmo_evt | ovr_evt;
  assign clr_tmo  = reg_wr & reg_wdata[BIT_TMO];
  assign clr_ovr  = reg_wr & reg_wdata[BIT_OVR];

  always_ff @(posedge clk) begin
    if (rst) begin
      ten        <= 1'b0;
      tval       <= '0;
      flag_tmo   <= 1'b0;
      flag_ovr   <= 1'b0;
      chan_en    <= 1'b0;
      irq_pulse  <= 1'b0;
      halt_pulse <= 1'b0;
    end else begin
      if (reg_wr) begin
        ten  <= reg_wdata[BIT_TEN];
        tval <= reg_wdata[TV_LSB +: TV_W];
      end
      flag_tmo <= flag_evt | (flag_tmo & ~clr_tmo);
      flag_ovr <= ovr_evt  | (flag_ovr & ~clr_ovr);
      if (ien && flag_evt) chan_en <= 1'b0;
      else if (en_wr)      chan_en <= en_wdata;
      irq_pulse  <= ien & flag_evt;
      halt_pulse <= flag_evt | err_evt;
    end
  end
endmodule

// File: rtl/rxdma_rx_timeout.sv
module rxdma_rx_timeout
  import rxdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [CSR_W-1:0] reg_wdata,
  output logic [CSR_W-1:0] reg_rdata,
  input  logic             ien,
  input  logic             en_wr,
  input  logic             en_wdata,
  output logic             chan_en,
  input  logic             byte_xfer,
  input  logic             sof_tick,
  input  logic             bufx_full,
  input  logic             bufy_full,
  input  logic             fifo_full,
  input  logic             uart_err,
  output logic             irq_pulse,
  output logic             halt_pulse
);
  logic            ten;
  logic [TV_W-1:0] tval;
  logic            flag_tmo;
  logic            flag_ovr;
  logic            tmo_evt;
  logic            ovr_evt;
  logic            err_evt;

  assign err_evt = uart_err & chan_en;

  rxdma_idle_timer #(.TV_W(TV_W)) timer_i (
    .clk        (clk),
    .rst        (rst),
    .ten        (ten),
    .tval       (tval),
    .chan_en    (chan_en),
    .byte_xfer  (byte_xfer),
    .sof_tick   (sof_tick),
    .other_term (ovr_evt | err_evt),
    .tmo_evt    (tmo_evt)
  );

  rxdma_ovr_detect ovr_i (
    .clk       (clk),
    .rst       (rst),
    .chan_en   (chan_en),
    .bufx_full (bufx_full),
    .bufy_full (bufy_full),
    .fifo_full (fifo_full),
    .ovr_evt   (ovr_evt)
  );

  rxdma_csr csr_i (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .ien        (ien),
    .en_wr      (en_wr),
    .en_wdata   (en_wdata),
    .tmo_evt    (tmo_evt),
    .ovr_evt    (ovr_evt),
    .err_evt    (err_evt),
    .ten        (ten),
    .tval       (tval),
    .flag_tmo   (flag_tmo),
    .flag_ovr   (flag_ovr),
    .chan_en    (chan_en),
    .irq_pulse  (irq_pulse),
    .halt_pulse (halt_pulse)
  );

  always_comb begin
    reg_rdata                      = '0;
    reg_rdata[BIT_TEN]             = ten;
    reg_rdata[TV_LSB +: TV_W]      = tval;
    reg_rdata[BIT_TMO]             = flag_tmo;
    reg_rdata[BIT_OVR]             = flag_ovr;
  end
endmodule

// File: rtl/rxdma_rx_timeout_chk.sv
module rxdma_rx_timeout_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       ien,
  input logic       chan_en,
  input logic       irq_pulse,
  input logic       halt_pulse
);
  AST_W0_KEEPS_TMO: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !reg_wdata[1] && reg_rdata[1]) |=> reg_rdata[1]); // R3
  AST_TMO_SET_HALTS: assert property (@(posedge clk) disable iff (rst)
    $rose(reg_rdata[1]) |-> halt_pulse); // R6
  AST_OVR_HAS_TMO: assert property (@(posedge clk) disable iff (rst)
    $rose(reg_rdata[0]) |-> reg_rdata[1]); // R7
  AST_NO_IRQ_IEN_LOW: assert property (@(posedge clk) disable iff (rst)
    !ien |=> !irq_pulse); // R9
  AST_IRQ_DROPS_EN: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> !chan_en); // R10
  AST_IRQ_WITH_HALT: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> halt_pulse); // R10
endmodule

bind rxdma_rx_timeout rxdma_rx_timeout_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .reg_wr     (reg_wr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .ien        (ien),
  .chan_en    (chan_en),
  .irq_pulse  (irq_pulse),
  .halt_pulse (halt_pulse)
);

// File: tb/rxdma_rx_timeout_tb_top.sv
module rxdma_rx_timeout_tb_top;
  localparam time CLK_PERIOD = 10ns;

  typedef struct packed {
    logic [3:0] req;
    logic       wr;
    logic [7:0] wd;
    logic       ew;
    logic       ed;
    logic       bt;
    logic       sf;
    logic       ov;
    logic       er;
    logic       ie;
    logic [7:0] rd;
    logic       en;
    logic       irq;
    logic       hlt;
  } vec_t;

  localparam logic Y = 1'b1;
  localparam logic N = 1'b0;
  localparam int NV = 34;

  // req | wr wd ew ed bt sf ov er ie | rd en irq hlt
  localparam vec_t TBL [NV] = '{
    '{4'd2,  Y,8'h88,Y,Y,N,N,N,N,N, 8'h88,Y,N,N}, // R2 R11 ten=1 value=2
    '{4'd5,  N,8'h00,N,N,N,Y,N,N,N, 8'h88,Y,N,N}, // R5 tick before first byte
    '{4'd4,  N,8'h00,N,N,Y,N,N,N,N, 8'h88,Y,N,N}, // R4 byte loads 2
    '{4'd6,  N,8'h00,N,N,N,Y,N,N,N, 8'h88,Y,N,N}, // R6 first tick, no expiry
    '{4'd4,  N,8'h00,N,N,Y,N,N,N,N, 8'h88,Y,N,N}, // R4 reload to 2
    '{4'd4,  N,8'h00,N,N,N,Y,N,N,N, 8'h88,Y,N,N}, // R4 tick 1 after reload
    '{4'd6,  N,8'h00,N,N,N,Y,N,N,N, 8'h8A,Y,N,Y}, // R6 R9 tick 2 expires
    '{4'd6,  N,8'h00,N,N,N,Y,N,N,N, 8'h8A,Y,N,N}, // R6 idle until next byte
    '{4'd3,  Y,8'h8A,N,N,N,N,N,N,N, 8'h88,Y,N,N}, // R3 clear timeout flag
    '{4'd7,  N,8'h00,N,N,N,N,Y,N,N, 8'h8B,Y,N,Y}, // R7 overrun sets both
    '{4'd7,  N,8'h00,N,N,N,N,Y,N,N, 8'h8B,Y,N,N}, // R7 held condition
    '{4'd3,  Y,8'h88,N,N,N,N,N,N,N, 8'h8B,Y,N,N}, // R3 write 0 no effect
    '{4'd3,  Y,8'h89,N,N,N,N,N,N,N, 8'h8A,Y,N,N}, // R3 clear overrun only
    '{4'd3,  Y,8'h8A,N,N,N,N,N,N,N, 8'h88,Y,N,N}, // R3 clear timeout
    '{4'd10, N,8'h00,N,N,Y,N,N,N,Y, 8'h88,Y,N,N}, // R10 byte with ien
    '{4'd10, N,8'h00,N,N,N,Y,N,N,Y, 8'h88,Y,N,N}, // R10 tick 1
    '{4'd10, N,8'h00,N,N,N,Y,N,N,Y, 8'h8A,N,Y,Y}, // R10 expiry drops enable
    '{4'd10, N,8'h00,N,N,N,N,N,N,Y, 8'h8A,N,N,N}, // R10 pulse lasts one cycle
    '{4'd11, Y,8'h02,Y,Y,N,N,N,N,Y, 8'h00,Y,N,N}, // R11 re-enable, ten=0
    '{4'd5,  N,8'h00,N,N,Y,N,N,N,Y, 8'h00,Y,N,N}, // R5 byte with ten=0
    '{4'd5,  N,8'h00,N,N,N,Y,N,N,Y, 8'h00,Y,N,N}, // R5 tick ignored, ten=0
    '{4'd2,  Y,8'h80,N,N,N,N,N,N,Y, 8'h80,Y,N,N}, // R2 ten=1 value 0
    '{4'd6,  N,8'h00,N,N,N,Y,N,N,Y, 8'h82,N,Y,Y}, // R6 zero value, first tick
    '{4'd11, Y,8'h82,Y,Y,N,N,N,N,N, 8'h80,Y,N,N}, // R11 re-enable
    '{4'd4,  N,8'h00,N,N,Y,Y,N,N,N, 8'h80,Y,N,N}, // R4 byte+tick reload wins
    '{4'd9,  N,8'h00,N,N,N,Y,N,N,N, 8'h82,Y,N,Y}, // R9 expiry, stays enabled
    '{4'd8,  N,8'h00,N,N,N,N,N,Y,N, 8'h82,Y,N,Y}, // R8 uart error halts
    '{4'd11, N,8'h00,Y,N,N,N,N,N,N, 8'h82,N,N,N}, // R11 disable channel
    '{4'd11, N,8'h00,N,N,Y,N,N,N,N, 8'h82,N,N,N}, // R11 byte ignored
    '{4'd11, N,8'h00,Y,Y,N,N,N,N,N, 8'h82,Y,N,N}, // R11 enable again
    '{4'd11, N,8'h00,N,N,N,Y,N,N,N, 8'h82,Y,N,N}, // R11 not armed by lost byte
    '{4'd4,  N,8'h00,N,N,Y,N,N,N,N, 8'h82,Y,N,N}, // R4 byte arms
    '{4'd3,  Y,8'h82,N,N,N,Y,N,N,N, 8'h82,Y,N,Y}, // R3 set beats clear
    '{4'd3,  Y,8'h82,N,N,N,N,N,N,N, 8'h80,Y,N,N}  // R3 clear afterwards
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       ien = 1'b0;
  logic       en_wr = 1'b0;
  logic       en_wdata = 1'b0;
  logic       chan_en;
  logic       byte_xfer = 1'b0;
  logic       sof_tick = 1'b0;
  logic       all_full = 1'b0;
  logic       uart_err = 1'b0;
  logic       irq_pulse;
  logic       halt_pulse;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxdma_rx_timeout dut_i (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .ien        (ien),
    .en_wr      (en_wr),
    .en_wdata   (en_wdata),
    .chan_en    (chan_en),
    .byte_xfer  (byte_xfer),
    .sof_tick   (sof_tick),
    .bufx_full  (all_full),
    .bufy_full  (all_full),
    .fifo_full  (all_full),
    .uart_err   (uart_err),
    .irq_pulse  (irq_pulse),
    .halt_pulse (halt_pulse)
  );

  task automatic check(input int req, input logic [10:0] act, input logic [10:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: rd/en/irq/halt actual %h/%b/%b/%b expected %h/%b/%b/%b",
               req, act[10:3], act[2], act[1], act[0], exp[10:3], exp[2], exp[1], exp[0]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(1, {reg_rdata, chan_en, irq_pulse, halt_pulse}, 11'h000);
    for (int i = 0; i < NV; i++) begin
      reg_wr    = TBL[i].wr;
      reg_wdata = TBL[i].wd;
      en_wr     = TBL[i].ew;
      en_wdata  = TBL[i].ed;
      byte_xfer = TBL[i].bt;
      sof_tick  = TBL[i].sf;
      all_full  = TBL[i].ov;
      uart_err  = TBL[i].er;
      ien       = TBL[i].ie;
      @(negedge clk);
      check(int'(TBL[i].req), {reg_rdata, chan_en, irq_pulse, halt_pulse},
            {TBL[i].rd, TBL[i].en, TBL[i].irq, TBL[i].hlt});
    end
    // R1 reset in the middle of activity: ten, value, flag and enable set
    reg_wr = 1'b0; en_wr = 1'b0; byte_xfer = 1'b0; sof_tick = 1'b0;
    all_full = 1'b0; uart_err = 1'b0;
    rst = 1'b1;
    sof_tick = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    sof_tick = 1'b0;
    @(negedge clk);
    check(1, {reg_rdata, chan_en, irq_pulse, halt_pulse}, 11'h000);
    // R7 overrun ignored while the channel is disabled
    all_full = 1'b1;
    @(negedge clk);
    check(7, {reg_rdata, chan_en, irq_pulse, halt_pulse}, 11'h000);
    all_full = 1'b0;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule